// File: doc/BRIEF.md
# Two-Tap Lock-In Gate Timing Sequencer

This block produces the three digital gate control lines of a two-tap time-gated pixel array: the transfer gate that steers charge into storage node 1, the transfer gate for storage node 2, and a drain gate that empties the photodiode. All times are whole ticks of the system clock. A frame starts on a start pulse and consists of an accumulation period followed by a fixed-length readout period. During accumulation a modulation cycle of programmable length is repeated a programmable number of times. In each cycle the first window opens at a programmable offset. The second window follows it at once, so that a decay is split into an early part and a late part. The drain gate is high whenever neither window is open. A light trigger pulse, placed at a programmable tick of each cycle, fires the pulsed excitation source.

In single-tap mode only the first window is used. A host scans the decay profile by changing the trigger delay from one frame to the next. All settings are captured when a frame starts and hold their value until it ends. Windows programmed to run past the end of the cycle are cut off at the cycle end.

Top module: `lockin_gate_seq`

## Requirements
- R1: After reset the block is idle: busy and done are low, both transfer gates and the light trigger are low, and the drain gate is high.
- R2: A start pulse seen while idle makes busy high from the next cycle until the end of readout. A start pulse seen while busy is ignored.
- R3: During accumulation, tap 1 is high exactly on the ticks t (counted from 0 within each cycle) with off <= t < off + w1len.
- R4: In dual mode (cfg_single = 0), tap 2 is high exactly on the ticks with off + w1len <= t < off + w1len + w2len.
- R5: During accumulation the drain gate is high exactly when both taps are low, and the two taps are never high together.
- R6: Window ticks at or beyond the cycle period never occur, so both windows are cut off at the end of the period.
- R7: Accumulation lasts max(reps,1) × period ticks, so a frame keeps busy high for that count plus READOUT_TICKS cycles.
- R8: For all READOUT_TICKS cycles of readout, and while idle, the drain gate is high and both taps are low.
- R9: done is high for exactly one cycle, in the cycle after the last readout cycle. A start in that cycle begins the next frame at once.
- R10: The light trigger is high during accumulation on tick trig_dly of every cycle, and never if trig_dly >= period.
- R11: In single-tap mode (cfg_single = 1), tap 2 stays low for the whole frame, and tap 1 follows R3.
- R12: All cfg_* inputs are sampled at the accepted start pulse. Changes during a frame have no effect on that frame.
- R13: A programmed period of 0 is treated as a period of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one tick of gate timing |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Frame start pulse |
| cfg_period | input | CNT_W | Modulation cycle length in ticks |
| cfg_w1_off | input | CNT_W | Tick at which window 1 opens |
| cfg_w1_len | input | CNT_W | Window 1 width in ticks |
| cfg_w2_len | input | CNT_W | Window 2 width in ticks |
| cfg_reps | input | REP_W | Number of cycles per frame |
| cfg_trig_dly | input | CNT_W | Tick of the light trigger within a cycle |
| cfg_single | input | 1 | 1 selects single-tap mode |
| gate_tap1 | output | 1 | Transfer gate to storage node 1 |
| gate_tap2 | output | 1 | Transfer gate to storage node 2 |
| gate_drain | output | 1 | Photodiode drain gate |
| light_trig | output | 1 | Excitation trigger pulse |
| busy | output | 1 | High for the whole frame |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A dual-mode frame with both windows inside the period shows whether the windows sit at the right place, abut each other and repeat the right number of times. Settings are changed and start is pulsed in the middle of that frame to tell latched settings from live inputs. A second frame places window 2 past the period end and the trigger beyond the period, which shows up any clipping or wrap-around fault. A run of back-to-back single-tap frames, each with the trigger delay one tick later, checks the delay scan, the quiet second tap and the done-to-start handover. A last frame with a zero period and zero repetitions probes the smallest legal frame.

// File: rtl/lockin_pkg.sv
// Shared types for the lock-in gate sequencer.
package lockin_pkg;
    // Frame phase: idle, accumulation (windows active), readout (gates parked).
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACC  = 2'd1,
        PH_READ = 2'd2
    } phase_t;
endpackage

// File: rtl/lockin_cfg_hold.sv
// Captures the frame settings on the accepted start pulse and holds them
// for the whole frame. Normalises a zero period or zero repetition count to 1.
// Assumes load is a single-cycle pulse issued only while idle.
module lockin_cfg_hold #(
    parameter int CNT_W = 16,
    parameter int REP_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] in_period,
    input  logic [CNT_W-1:0] in_w1_off,
    input  logic [CNT_W-1:0] in_w1_len,
    input  logic [CNT_W-1:0] in_w2_len,
    input  logic [REP_W-1:0] in_reps,
    input  logic [CNT_W-1:0] in_trig_dly,
    input  logic             in_single,
    output logic [CNT_W-1:0] period_q,
    output logic [CNT_W-1:0] w1_off_q,
    output logic [CNT_W-1:0] w1_len_q,
    output logic [CNT_W-1:0] w2_len_q,
    output logic [REP_W-1:0] reps_q,
    output logic [CNT_W-1:0] trig_dly_q,
    output logic             single_q
);
    // Latch all settings at frame start; zero period/count become one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q   <= CNT_W'(1);
            w1_off_q   <= '0;
            w1_len_q   <= '0;
            w2_len_q   <= '0;
            reps_q     <= REP_W'(1);
            trig_dly_q <= '0;
            single_q   <= 1'b0;
        end else if (load) begin
            period_q   <= (in_period == '0) ? CNT_W'(1) : in_period;
            w1_off_q   <= in_w1_off;
            w1_len_q   <= in_w1_len;
            w2_len_q   <= in_w2_len;
            reps_q     <= (in_reps == '0) ? REP_W'(1) : in_reps;
            trig_dly_q <= in_trig_dly;
            single_q   <= in_single;
        end
    end
endmodule

// File: rtl/lockin_frame_ctrl.sv
// Frame phase controller: counts ticks within a modulation cycle, cycles
// within accumulation, and cycles of readout; raises done after readout.
// Assumes period and reps inputs are non-zero and stable during a frame.
module lockin_frame_ctrl
    import lockin_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int REP_W        = 20,
    parameter int READOUT_TICKS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] period,
    input  logic [REP_W-1:0] reps,
    output phase_t           phase,
    output logic [CNT_W-1:0] tick,
    output logic             load,
    output logic             done
);
    localparam int RD_W = (READOUT_TICKS > 1) ? $clog2(READOUT_TICKS) : 1;
    localparam logic [RD_W-1:0] RD_LAST = RD_W'(READOUT_TICKS - 1);

    logic [REP_W-1:0] rep;
    logic [RD_W-1:0]  rd_cnt;
    logic             cyc_last;

    // A start pulse is accepted only while idle.
    assign load     = (phase == PH_IDLE) && start;
    // Last tick of the current modulation cycle.
    assign cyc_last = (tick == period - CNT_W'(1));

    // Phase sequencing and the three counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            tick   <= '0;
            rep    <= '0;
            rd_cnt <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_ACC;
                        tick  <= '0;
                        rep   <= '0;
                    end
                end
                PH_ACC: begin
                    if (cyc_last) begin
                        tick <= '0;
                        if (rep == reps - REP_W'(1)) begin
                            phase  <= PH_READ;
                            rd_cnt <= '0;
                        end else begin
                            rep <= rep + REP_W'(1);
                        end
                    end else begin
                        tick <= tick + CNT_W'(1);
                    end
                end
                PH_READ: begin
                    if (rd_cnt == RD_LAST) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        rd_cnt <= rd_cnt + RD_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R6: the tick counter never reaches the cycle period.
    assert_tick_in_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACC) |-> (tick < period));

    // R9: done appears only right after the readout phase.
    assert_done_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == PH_IDLE) && ($past(phase) == PH_READ));

    // R7: the repetition counter stays below the programmed count.
    assert_rep_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACC) |-> (rep < reps));
endmodule

// File: rtl/lockin_gate_decode.sv
// Decodes the tick position into the two transfer windows, the drain gate
// and the light trigger. Window 2 abuts window 1; windows past the period
// vanish because the tick never reaches the period. Outside accumulation
// the gates are parked with the drain open.
module lockin_gate_decode
    import lockin_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_t           phase,
    input  logic [CNT_W-1:0] tick,
    input  logic [CNT_W-1:0] w1_off,
    input  logic [CNT_W-1:0] w1_len,
    input  logic [CNT_W-1:0] w2_len,
    input  logic [CNT_W-1:0] trig_dly,
    input  logic             single,
    output logic             tap1,
    output logic             tap2,
    output logic             drain,
    output logic             trig
);
    logic [CNT_W:0]   w1_end;
    logic [CNT_W+1:0] w2_end;
    logic             in_w1;
    logic             in_w2;
    logic             acc;

    // Window boundaries with carry bits so no sum wraps.
    assign w1_end = {1'b0, w1_off} + {1'b0, w1_len};
    assign w2_end = {1'b0, w1_end} + {2'b0, w2_len};

    // Window membership of the current tick.
    assign acc   = (phase == PH_ACC);
    assign in_w1 = (tick >= w1_off) && ({1'b0, tick} < w1_end);
    assign in_w2 = !single && ({1'b0, tick} >= w1_end) && ({2'b0, tick} < w2_end);

    // Gate outputs; drain opens whenever no window does.
    assign tap1  = acc && in_w1;
    assign tap2  = acc && in_w2;
    assign drain = !(tap1 || tap2);
    assign trig  = acc && (tick == trig_dly);

    // R5: never both transfer gates at once.
    assert_tap_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tap1, tap2}));

    // R11: single-tap mode keeps tap 2 closed.
    assert_single_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        single |-> !tap2);
endmodule

// File: rtl/lockin_gate_seq.sv
// Top of the two-tap lock-in gate timing sequencer. Ties the settings
// holder, the frame controller and the gate decoder together.
// Assumes start is synchronous to clk; all times are in clk ticks.
module lockin_gate_seq
    import lockin_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int REP_W         = 20,
    parameter int READOUT_TICKS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_w1_off,
    input  logic [CNT_W-1:0] cfg_w1_len,
    input  logic [CNT_W-1:0] cfg_w2_len,
    input  logic [REP_W-1:0] cfg_reps,
    input  logic [CNT_W-1:0] cfg_trig_dly,
    input  logic             cfg_single,
    output logic             gate_tap1,
    output logic             gate_tap2,
    output logic             gate_drain,
    output logic             light_trig,
    output logic             busy,
    output logic             done
);
    phase_t           phase;
    logic [CNT_W-1:0] tick;
    logic             load;
    logic [CNT_W-1:0] period_q, w1_off_q, w1_len_q, w2_len_q, trig_dly_q;
    logic [REP_W-1:0] reps_q;
    logic             single_q;

    lockin_cfg_hold #(.CNT_W(CNT_W), .REP_W(REP_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(load),
        .in_period(cfg_period), .in_w1_off(cfg_w1_off), .in_w1_len(cfg_w1_len),
        .in_w2_len(cfg_w2_len), .in_reps(cfg_reps), .in_trig_dly(cfg_trig_dly),
        .in_single(cfg_single),
        .period_q(period_q), .w1_off_q(w1_off_q), .w1_len_q(w1_len_q),
        .w2_len_q(w2_len_q), .reps_q(reps_q), .trig_dly_q(trig_dly_q),
        .single_q(single_q)
    );

    lockin_frame_ctrl #(.CNT_W(CNT_W), .REP_W(REP_W), .READOUT_TICKS(READOUT_TICKS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .period(period_q), .reps(reps_q),
        .phase(phase), .tick(tick), .load(load), .done(done)
    );

    lockin_gate_decode #(.CNT_W(CNT_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .phase(phase), .tick(tick),
        .w1_off(w1_off_q), .w1_len(w1_len_q), .w2_len(w2_len_q),
        .trig_dly(trig_dly_q), .single(single_q),
        .tap1(gate_tap1), .tap2(gate_tap2), .drain(gate_drain), .trig(light_trig)
    );

    // Frame activity flag.
    assign busy = (phase != PH_IDLE);

    // R2: an idle start makes the block busy on the next cycle.
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R8: outside accumulation the gates are parked with drain open.
    assert_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_ACC) |-> (gate_drain && !gate_tap1 && !gate_tap2));

    // R10: the light trigger fires only inside a frame.
    assert_trig_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        light_trig |-> busy);
endmodule

// File: tb/sim_lockin_gate_seq.sv
`timescale 1ns/1ps
module sim_lockin_gate_seq;
    localparam int CW = 16;
    localparam int RW = 20;
    localparam int RDT = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CW-1:0] cfg_period = '0, cfg_w1_off = '0, cfg_w1_len = '0;
    logic [CW-1:0] cfg_w2_len = '0, cfg_trig_dly = '0;
    logic [RW-1:0] cfg_reps = '0;
    logic cfg_single = 1'b0;
    logic tap1, tap2, drn, trg, busy, done;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int tap2_seen = 0;

    always #2.5 clk = ~clk;

    lockin_gate_seq #(.CNT_W(CW), .REP_W(RW), .READOUT_TICKS(RDT)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_period(cfg_period), .cfg_w1_off(cfg_w1_off), .cfg_w1_len(cfg_w1_len),
        .cfg_w2_len(cfg_w2_len), .cfg_reps(cfg_reps), .cfg_trig_dly(cfg_trig_dly),
        .cfg_single(cfg_single),
        .gate_tap1(tap1), .gate_tap2(tap2), .gate_drain(drn), .light_trig(trg),
        .busy(busy), .done(done)
    );

    // Behavioural reference: 0 idle, 1 accumulate, 2 readout.
    int m_st = 0, m_t = 0, m_rep = 0, m_rd = 0, m_done = 0;
    int m_p = 1, m_off = 0, m_w1 = 0, m_w2 = 0, m_n = 1, m_dly = 0, m_single = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_st == 0) begin
                if (start) begin
                    m_st = 1; m_t = 0; m_rep = 0;
                    m_p = (cfg_period == 0) ? 1 : int'(cfg_period);
                    m_n = (cfg_reps == 0) ? 1 : int'(cfg_reps);
                    m_off = int'(cfg_w1_off); m_w1 = int'(cfg_w1_len);
                    m_w2 = int'(cfg_w2_len); m_dly = int'(cfg_trig_dly);
                    m_single = int'(cfg_single);
                end
            end else if (m_st == 1) begin
                m_t++;
                if (m_t == m_p) begin
                    m_t = 0; m_rep++;
                    if (m_rep == m_n) begin m_st = 2; m_rd = 0; end
                end
            end else begin
                m_rd++;
                if (m_rd == RDT) begin m_st = 0; m_done = 1; end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int e1, e2, ed, et;
            bit a;
            a  = (m_st == 1);
            e1 = (a && m_t >= m_off && m_t < m_off + m_w1) ? 1 : 0;
            e2 = (a && !m_single && m_t >= m_off + m_w1 && m_t < m_off + m_w1 + m_w2) ? 1 : 0;
            ed = (e1 == 0 && e2 == 0) ? 1 : 0;
            et = (a && m_t == m_dly) ? 1 : 0;
            chk(int'(tap1) == e1, "R3", "tap1", int'(tap1), e1);
            chk(int'(tap2) == e2, "R4", "tap2", int'(tap2), e2);
            chk(int'(drn) == ed, "R5", "drain", int'(drn), ed);
            chk(int'(trg) == et, "R10", "trig", int'(trg), et);
            chk(int'(busy) == ((m_st != 0) ? 1 : 0), "R2", "busy", int'(busy), (m_st != 0) ? 1 : 0);
            chk(int'(done) == m_done, "R9", "done", int'(done), m_done);
            if (tap2) tap2_seen++;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Program the settings, pulse start, count busy cycles and check the length (R7).
    task automatic run_frame(input int p, input int off, input int w1, input int w2,
                             input int reps, input int dly, input bit single,
                             input bit disturb, input string req);
        int cnt, exp_len;
        cfg_period = CW'(p); cfg_w1_off = CW'(off); cfg_w1_len = CW'(w1);
        cfg_w2_len = CW'(w2); cfg_reps = RW'(reps); cfg_trig_dly = CW'(dly);
        cfg_single = single;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (busy) begin
            cnt++;
            if (disturb && cnt == 5) begin
                // R12 / R2: new settings and a stray start mid-frame must not matter.
                cfg_period = 7; cfg_w1_off = 0; cfg_w1_len = 1; cfg_w2_len = 1;
                cfg_reps = 1; cfg_trig_dly = 0; cfg_single = 1'b1; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        exp_len = ((reps == 0) ? 1 : reps) * ((p == 0) ? 1 : p) + RDT;
        chk(cnt == exp_len, req, "frame length", cnt, exp_len);
        chk(done == 1'b1, "R9", "done after frame", int'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(busy == 0 && done == 0, "R1", "busy/done", int'({busy, done}), 0);
        chk(tap1 == 0 && tap2 == 0 && trg == 0, "R1", "taps/trig", int'({tap1, tap2, trg}), 0);
        chk(drn == 1, "R1", "drain", int'(drn), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 0 && drn == 1, "R8", "idle parked", int'({busy, drn}), 1);

        // R3 R4 R7 R12: dual mode, both windows inside the period, settings disturbed.
        run_frame(20, 3, 5, 6, 4, 2, 1'b0, 1'b1, "R12");
        @(negedge clk);
        // R6 R10: window 2 beyond the period end, trigger beyond the period.
        run_frame(10, 4, 4, 8, 3, 15, 1'b0, 1'b0, "R6");
        // R6: window 1 itself overrunning the period.
        run_frame(8, 6, 9, 3, 2, 7, 1'b0, 1'b0, "R6");

        // R11 R9: back-to-back single-tap delay scan, trigger one tick later each frame.
        tap2_seen = 0;
        for (int d = 0; d < 6; d++)
            run_frame(12, 2, 4, 5, 2, d, 1'b1, 1'b0, "R11");
        chk(tap2_seen == 0, "R11", "tap2 high cycles", tap2_seen, 0);

        // R13 R7: zero period and zero repetitions give the shortest frame.
        run_frame(0, 0, 1, 1, 0, 0, 1'b0, 1'b0, "R13");
        // R8: readout with a long accumulation before it.
        run_frame(16, 0, 8, 8, 10, 0, 1'b0, 1'b0, "R8");

        repeat (4) @(negedge clk);
        chk(busy == 0 && done == 0, "R9", "done is one cycle", int'({busy, done}), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule